// File: doc/BRIEF.md
# APB Manager Error Capture Unit

This block sits on the manager or bridge side of an APB bus and turns the subordinate's error flag into something the system can act on. It watches the handshake, takes the error flag into account only on the completion cycle (select, enable and ready all high), and treats every other value of that flag as noise. A completed access counts as completed whether it failed or not. The unit never cancels, stalls or repeats a transfer.

An erroring completion has two possible consequences. If the access carried the fault-critical attribute, the unit raises a single-cycle bus-fault pulse. Every erroring completion also sets a sticky status bit that software can poll, records the address and direction of the first failure since the last clear, and increments a saturating error counter. Read data returned on a completion is forwarded on a valid strobe. Data that came back with an error is marked suspect. The read-data output is a valid-only stream with no back-pressure. The consumer must take each beat in the cycle it appears, because APB itself cannot be held once it has completed.

Top module: `apb_err_capture`

## Requirements
- R1: A completion is recognised only in a cycle where psel, penable and pready are all 1. The error flag and the other bus inputs have no effect on any output in any other cycle.
- R2: One cycle after each read completion (pwrite=0), rd_valid is 1 for exactly one cycle and rd_data carries the prdata value of that completion. This holds whether the error flag was 0 or 1. A write completion never raises rd_valid.
- R3: rd_suspect is 1 exactly when rd_valid is 1 and that read completed with the error flag at 1.
- R4: bus_fault is 1 for exactly one cycle, the cycle after an erroring completion whose fault_crit was 1. At all other times it is 0.
- R5: err_sticky becomes 1 in the cycle after an erroring completion and stays 1 until a cycle with sw_clear=1. If an erroring completion falls in the same cycle as sw_clear, the bit stays 1.
- R6: The first erroring completion after reset or after a clear (including one in the same cycle as the clear) loads cap_addr with paddr and cap_write with pwrite. Later errors leave both unchanged and set err_overflow.
- R7: A completion with the error flag at 0 never sets bus_fault, err_sticky, err_overflow or the counter.
- R8: err_count adds 1 for each erroring completion and stops at 255. It is cleared only by reset.
- R9: After reset every output is 0.
- R10: sw_clear without a coincident error clears err_sticky and err_overflow, and leaves cap_addr, cap_write and err_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pready | input | 1 | APB ready from subordinate |
| pslverr | input | 1 | APB error flag from subordinate |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB address |
| prdata | input | DATA_W | APB read data |
| fault_crit | input | 1 | Current access is fault-critical |
| sw_clear | input | 1 | Write-1-to-clear pulse for the sticky record |
| bus_fault | output | 1 | One-cycle fault pulse |
| rd_valid | output | 1 | Read beat valid (no back-pressure) |
| rd_suspect | output | 1 | Read beat completed with error |
| rd_data | output | DATA_W | Read beat data |
| err_sticky | output | 1 | Sticky error status |
| err_overflow | output | 1 | More than one error since last clear |
| cap_addr | output | ADDR_W | Address of first captured error |
| cap_write | output | 1 | Direction of first captured error |
| err_count | output | CNT_W | Saturating error count |

## Verification
The bench builds the unit with ADDR_W=8, DATA_W=8 and CNT_W=8. That keeps the counter at its full 255 limit, so saturation can be reached in a few hundred short accesses. The bench sweeps every combination of direction, fault-critical attribute, error verdict and zero to two wait states. During setup and wait cycles it holds the error flag high, so any sampling outside the completion cycle shows up. It also places a clear both on its own and on the same cycle as an erroring completion, and it drives the error count past its limit.

// File: rtl/apb_ecap_pkg.sv
package apb_ecap_pkg;
  // Per-completion verdict handed from the sampler to the consumers.
  typedef struct packed {
    logic done;   // a transfer completed this cycle
    logic err;    // it completed with the error flag set
    logic rd;     // it was a read
    logic crit;   // it was marked fault-critical
  } verdict_t;
endpackage

// File: rtl/apb_ecap_sample.sv
module apb_ecap_sample
  import apb_ecap_pkg::*;
(
  input  logic     psel,
  input  logic     penable,
  input  logic     pready,
  input  logic     pslverr,
  input  logic     pwrite,
  input  logic     fault_crit,
  output verdict_t vd
);
  logic cpl;
  assign cpl     = psel & penable & pready;
  // Every field is gated by the completion so nothing leaks from wait cycles.
  assign vd.done = cpl;
  assign vd.err  = cpl & pslverr;
  assign vd.rd   = cpl & ~pwrite;
  assign vd.crit = cpl & fault_crit;
endmodule

// File: rtl/apb_ecap_record.sv
module apb_ecap_record #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_in,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_in,
  output logic              sticky,
  output logic              ovf,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_wr
);
  logic first;
  // A clear in the same cycle opens the record again, so that error counts as first.
  assign first = err_in & (~sticky | clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky   <= 1'b0;
      ovf      <= 1'b0;
      cap_addr <= '0;
      cap_wr   <= 1'b0;
    end else begin
      if (err_in)   sticky <= 1'b1;
      else if (clr) sticky <= 1'b0;

      if (first)       ovf <= 1'b0;
      else if (err_in) ovf <= 1'b1;
      else if (clr)    ovf <= 1'b0;

      if (first) begin
        cap_addr <= addr_in;
        cap_wr   <= wr_in;
      end
    end
  end

  a_r5_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !clr) |=> sticky);
  a_r6_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !clr) |=> ($stable(cap_addr) && $stable(cap_wr)));
  a_r7_rise_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky) |-> $past(err_in));
  a_r6_ovf_needs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> sticky);
endmodule

// File: rtl/apb_ecap_counter.sv
module apb_ecap_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic full;
  assign full = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (inc && !full) cnt <= cnt + 1'b1;
  end

  a_r8_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt) |=> (&cnt));
  a_r8_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/apb_ecap_respond.sv
module apb_ecap_respond
  import apb_ecap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  verdict_t          vd,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              fault,
  output logic              rvalid,
  output logic              rsuspect,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault    <= 1'b0;
      rvalid   <= 1'b0;
      rsuspect <= 1'b0;
      rdata    <= '0;
    end else begin
      fault    <= vd.err & vd.crit;
      rvalid   <= vd.rd;
      rsuspect <= vd.rd & vd.err;
      if (vd.rd) rdata <= rdata_in;
    end
  end

  a_r3_suspect_only_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rsuspect |-> rvalid);
  a_r4_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(vd.err && vd.crit));
endmodule

// File: rtl/apb_err_capture.sv
module apb_err_capture
  import apb_ecap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pready,
  input  logic              pslverr,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] prdata,
  input  logic              fault_crit,
  input  logic              sw_clear,
  output logic              bus_fault,
  output logic              rd_valid,
  output logic              rd_suspect,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_sticky,
  output logic              err_overflow,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_write,
  output logic [CNT_W-1:0]  err_count
);
  verdict_t vd;

  apb_ecap_sample u_sample (
    .psel(psel), .penable(penable), .pready(pready), .pslverr(pslverr),
    .pwrite(pwrite), .fault_crit(fault_crit), .vd(vd)
  );

  apb_ecap_record #(.ADDR_W(ADDR_W)) u_record (
    .clk(clk), .rst_n(rst_n), .err_in(vd.err), .clr(sw_clear),
    .addr_in(paddr), .wr_in(pwrite), .sticky(err_sticky), .ovf(err_overflow),
    .cap_addr(cap_addr), .cap_wr(cap_write)
  );

  apb_ecap_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(vd.err), .cnt(err_count)
  );

  apb_ecap_respond #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .vd(vd), .rdata_in(prdata),
    .fault(bus_fault), .rvalid(rd_valid), .rsuspect(rd_suspect), .rdata(rd_data)
  );

  a_r1_beat_needs_completion: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(psel && penable && pready && !pwrite));
  a_r4_fault_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |-> $past(psel && penable && pready && pslverr && fault_crit));
  a_r7_count_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> $past(psel && penable && pready && pslverr));
endmodule

// File: tb/tb_apb_err_capture.sv
`timescale 1ns/1ps
module tb_apb_err_capture;
  localparam int AW = 8, DW = 8, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pready = 0, pslverr = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] prdata = '0;
  logic fault_crit = 0, sw_clear = 0;
  logic bus_fault, rd_valid, rd_suspect, err_sticky, err_overflow, cap_write;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] cap_addr;
  logic [CW-1:0] err_count;

  always #4 clk = ~clk;

  apb_err_capture #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // reference model state
  bit m_sticky = 0, m_ovf = 0, m_capw = 0;
  int m_capa = 0, m_cnt = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_status(string tag);
    chk({tag, " R5 sticky"}, int'(err_sticky), int'(m_sticky));
    chk({tag, " R6 overflow"}, int'(err_overflow), int'(m_ovf));
    chk({tag, " R6 cap_addr"}, int'(cap_addr), m_capa);
    chk({tag, " R6 cap_write"}, int'(cap_write), int'(m_capw));
    chk({tag, " R8 count"}, int'(err_count), m_cnt);
  endtask

  task automatic access(int a, bit wr, bit crit, bit err, int waits, bit clr_at);
    logic [DW-1:0] d;
    d = DW'(a ^ 8'h5A);
    @(negedge clk);
    psel = 1; penable = 0; pready = 1; pslverr = 1; pwrite = wr;
    paddr = AW'(a); fault_crit = crit; prdata = ~d;
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      // R1: setup/wait cycle had the error flag high; nothing may react
      chk("R1 no fault outside completion", int'(bus_fault), 0);
      chk("R1 no beat outside completion", int'(rd_valid), 0);
      penable = 1; pready = 0; pslverr = 1; prdata = ~d;
    end
    @(negedge clk);
    chk("R1 no fault before completion", int'(bus_fault), 0);
    penable = 1; pready = 1; pslverr = err; prdata = d; sw_clear = clr_at;
    @(negedge clk);
    // model update for the completion just taken
    if (err) begin
      if (!m_sticky || clr_at) begin m_capa = a; m_capw = wr; m_ovf = 0; end
      else m_ovf = 1;
      m_sticky = 1;
      if (m_cnt < 255) m_cnt++;
    end else if (clr_at) begin
      m_sticky = 0; m_ovf = 0;
    end
    chk("R4 fault pulse", int'(bus_fault), int'(err && crit));
    chk("R2 read beat valid", int'(rd_valid), int'(!wr));
    if (!wr) chk("R2 read data", int'(rd_data), int'(d));
    chk("R3 suspect flag", int'(rd_suspect), int'(err && !wr));
    chk_status("R7 after completion");
    psel = 0; penable = 0; pready = 1; pslverr = 1; sw_clear = 0; prdata = ~d;
    @(negedge clk);
    chk("R4 fault lasts one cycle", int'(bus_fault), 0);
    chk("R2 beat lasts one cycle", int'(rd_valid), 0);
    chk_status("R1 after idle with junk error");
  endtask

  task automatic clear_only();
    @(negedge clk); sw_clear = 1;
    @(negedge clk); sw_clear = 0;
    m_sticky = 0; m_ovf = 0;
    chk_status("R10 clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset fault", int'(bus_fault), 0);
    chk("R9 reset beat", int'(rd_valid), 0);
    chk_status("R9 reset");
    rst_n = 1;
    // near-exhaustive sweep
    for (int wt = 0; wt < 3; wt++)
      for (int wr = 0; wr < 2; wr++)
        for (int cr = 0; cr < 2; cr++)
          for (int er = 0; er < 2; er++)
            access(wt*16 + wr*8 + cr*4 + er*2 + 1, wr[0], cr[0], er[0], wt, 1'b0);
    clear_only();
    access(8'h33, 1'b0, 1'b0, 1'b0, 1, 1'b0);   // R7 clean after clear
    access(8'h44, 1'b1, 1'b1, 1'b1, 0, 1'b0);   // first error after clear
    access(8'h55, 1'b0, 1'b0, 1'b1, 2, 1'b0);   // overflow
    access(8'h66, 1'b0, 1'b1, 1'b1, 1, 1'b1);   // R5 error with clear same cycle
    access(8'h77, 1'b1, 1'b0, 1'b0, 0, 1'b1);   // R10 clear with clean completion
    for (int i = 0; i < 250; i++)
      access(i, i[0], i[1], 1'b1, 0, 1'b0);     // R8 drive past saturation
    chk("R8 saturated at 255", int'(err_count), 255);
    clear_only();
    chk("R8 count survives clear", int'(err_count), 255);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule